// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the reference pre-divider N and the feedback multiplier M for a serial-lane PLL so that the resulting VCO frequency lands as close as possible to a desired per-lane bit rate. The desired rate is derived from the pixel clock, the bits per pixel and the number of lanes. A single start strobe captures all inputs. The engine then steps through every legal N, one candidate at a time, and reports the winner with a one-cycle done strobe.

All divisions share one iterative restoring divider, so the block stays small and the search takes a few dozen cycles per candidate. The achieved lane rate, in Mbps, is reported next to N and M. If no candidate meets the limits, an error flag is raised with the done strobe.

Top module: `pll_div_search`

## Requirements
- R1: The target rate in Mbps is computed as r = bpp / lanes, then t = ((pclk_khz * r * 10) / 8) / 1000. Every division here is an integer division that truncates.
- R2: When pclk_khz is 0, or when t is 1500 or more, the target is 1000 Mbps. The target in Hz is the target in Mbps times 1,000,000.
- R3: Candidate N values run upward from ceil(fref_hz / 40,000,000) to floor(fref_hz / 5,000,000), both ends included.
- R4: For each N, M = floor(target_Hz * N / fref_hz). The candidate is skipped if M < 6 or M > 512. Otherwise an odd M is raised by 1, and n_best and m_best report that even M.
- R5: The VCO frequency is floor(M * fref_hz / N). A candidate counts only if this value lies between 80,000,000 and 1,500,000,000 inclusive.
- R6: The kept candidate has the smallest absolute difference between its VCO frequency and the target in Hz. A later (larger) N replaces it only when its difference is strictly smaller.
- R7: lane_mbps is the kept VCO frequency divided by 1,000,000, rounded up.
- R8: If no candidate counts, done comes with err = 1 and n_best, m_best and lane_mbps all equal 0. Otherwise err = 0.
- R9: done is high for exactly one cycle per search. The outputs keep their value until the next done.
- R10: The inputs are captured on the cycle an accepted start is seen. A start that arrives while a search runs is ignored and has no effect on the result.
- R11: After reset, done, err, n_best, m_best and lane_mbps are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search; ignored while busy |
| fref_hz | input | FW (32) | PLL reference frequency in Hz |
| pclk_khz | input | PW (32) | Pixel clock in kHz |
| bpp | input | BW (6) | Bits per pixel |
| lanes | input | LW (3) | Number of data lanes |
| n_best | output | NW (12) | Chosen input divider |
| m_best | output | MW (10) | Chosen feedback multiplier |
| lane_mbps | output | RW (11) | Achieved lane rate, Mbps, rounded up |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | No valid candidate, valid with done |

## Verification
The assertions assume that lanes is at least 1 and that fref_hz is non-zero at every accepted start. Under those conditions no division by zero occurs, and the reported N is at least 1. The random stimulus draws lanes from 1 to 4 and fref_hz from 5 MHz to 100 MHz. The directed cases go below 5 MHz, but never to zero. Pixel clocks run from zero to values well above the 1500 Mbps cap, so both the fallback target and the exact boundary values get exercised.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FW = 32,
  parameter int PW = 32,
  parameter int BW = 6,
  parameter int LW = 3,
  parameter int NW = 12,
  parameter int MW = 10,
  parameter int RW = 11,
  parameter int DW = 48,
  parameter int unsigned REF_LO_HZ = 5000000,
  parameter int unsigned REF_HI_HZ = 40000000,
  parameter int unsigned VCO_LO_HZ = 80000000,
  parameter int unsigned VCO_HI_HZ = 1500000000,
  parameter int unsigned M_MIN = 6,
  parameter int unsigned M_MAX = 512,
  parameter int unsigned RATE_CAP = 1500,
  parameter int unsigned RATE_DEF = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] fref_hz,
  input  logic [PW-1:0] pclk_khz,
  input  logic [BW-1:0] bpp,
  input  logic [LW-1:0] lanes,
  output logic [NW-1:0] n_best,
  output logic [MW-1:0] m_best,
  output logic [RW-1:0] lane_mbps,
  output logic          done,
  output logic          err
);
  localparam int CW = $clog2(DW + 1);
  localparam int unsigned MHZ = 1000000;

  typedef enum logic [3:0] {
    S_IDLE, S_RATIO, S_TGT, S_NLO, S_NHI, S_LOOP, S_M, S_V, S_RATE
  } st_t;

  st_t st;
  logic [FW-1:0] fref_r;
  logic [PW-1:0] pclk_r;
  logic [BW-1:0] bpp_r, ratio;
  logic [LW-1:0] lanes_r;
  logic [FW-1:0] tgt_hz, best_v;
  logic [NW-1:0] n_cur, n_hi, n_keep;
  logic [MW-1:0] m_cur, m_keep;
  logic [DW-1:0] best_d;
  logic          found;
  logic          busy;

  logic          dv_run, dv_fin;
  logic [CW-1:0] dv_cnt;
  logic [DW-1:0] dv_q;
  logic [FW-1:0] dv_rem, dv_b;
  logic [FW:0]   dv_sh;
  logic [FW+1:0] dv_diff;

  logic [DW-1:0] op_a;
  logic [FW-1:0] op_b;
  logic          need_div;
  logic [RW-1:0] tgt_mbps;
  logic [DW-1:0] delta;
  logic          vco_ok;

  assign busy     = (st != S_IDLE);
  assign need_div = busy && (st != S_LOOP);
  assign dv_sh    = {dv_rem, dv_q[DW-1]};
  assign dv_diff  = {1'b0, dv_sh} - {2'b00, dv_b};

  assign tgt_mbps = ((pclk_r != '0) && (dv_q < DW'(RATE_CAP))) ? dv_q[RW-1:0] : RW'(RATE_DEF);
  assign delta    = (dv_q > DW'(tgt_hz)) ? dv_q - DW'(tgt_hz) : DW'(tgt_hz) - dv_q;
  assign vco_ok   = (dv_q >= DW'(VCO_LO_HZ)) && (dv_q <= DW'(VCO_HI_HZ));

  always_comb begin
    op_a = '0;
    op_b = FW'(1);
    case (st)
      S_RATIO: begin op_a = DW'(bpp_r); op_b = FW'(lanes_r); end
      S_TGT:   begin op_a = (DW'(pclk_r) * DW'(ratio) * DW'(10)) >> 3; op_b = FW'(1000); end
      S_NLO:   begin op_a = DW'(fref_r) + DW'(REF_HI_HZ - 1); op_b = FW'(REF_HI_HZ); end
      S_NHI:   begin op_a = DW'(fref_r); op_b = FW'(REF_LO_HZ); end
      S_M:     begin op_a = DW'(tgt_hz) * DW'(n_cur); op_b = fref_r; end
      S_V:     begin op_a = DW'(m_cur) * DW'(fref_r); op_b = FW'(n_cur); end
      S_RATE:  begin op_a = DW'(best_v) + DW'(MHZ - 1); op_b = FW'(MHZ); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      fref_r <= '0; pclk_r <= '0; bpp_r <= '0; lanes_r <= '0; ratio <= '0;
      tgt_hz <= '0; best_v <= '0; best_d <= '0; found <= 1'b0;
      n_cur <= '0; n_hi <= '0; n_keep <= '0; m_cur <= '0; m_keep <= '0;
      dv_run <= 1'b0; dv_fin <= 1'b0; dv_cnt <= '0; dv_q <= '0; dv_rem <= '0; dv_b <= '0;
      n_best <= '0; m_best <= '0; lane_mbps <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      done <= 1'b0;

      if (dv_run) begin
        if (!dv_diff[FW+1]) begin
          dv_rem <= dv_diff[FW-1:0];
          dv_q   <= {dv_q[DW-2:0], 1'b1};
        end else begin
          dv_rem <= dv_sh[FW-1:0];
          dv_q   <= {dv_q[DW-2:0], 1'b0};
        end
        dv_cnt <= dv_cnt - 1'b1;
        if (dv_cnt == CW'(1)) begin
          dv_run <= 1'b0;
          dv_fin <= 1'b1;
        end
      end else if (need_div && !dv_fin) begin
        dv_q   <= op_a;
        dv_b   <= op_b;
        dv_rem <= '0;
        dv_cnt <= CW'(DW);
        dv_run <= 1'b1;
      end

      if (dv_fin) dv_fin <= 1'b0;

      case (st)
        S_IDLE: if (start) begin
          fref_r <= fref_hz; pclk_r <= pclk_khz; bpp_r <= bpp; lanes_r <= lanes;
          found <= 1'b0;
          st <= S_RATIO;
        end
        S_RATIO: if (dv_fin) begin
          ratio <= dv_q[BW-1:0];
          st <= S_TGT;
        end
        S_TGT: if (dv_fin) begin
          tgt_hz <= FW'(DW'(tgt_mbps) * DW'(MHZ));
          st <= S_NLO;
        end
        S_NLO: if (dv_fin) begin
          n_cur <= dv_q[NW-1:0];
          st <= S_NHI;
        end
        S_NHI: if (dv_fin) begin
          n_hi <= dv_q[NW-1:0];
          st <= S_LOOP;
        end
        S_LOOP: begin
          if (n_cur > n_hi) begin
            if (found) st <= S_RATE;
            else begin
              done <= 1'b1; err <= 1'b1;
              n_best <= '0; m_best <= '0; lane_mbps <= '0;
              st <= S_IDLE;
            end
          end else st <= S_M;
        end
        S_M: if (dv_fin) begin
          if (dv_q < DW'(M_MIN) || dv_q > DW'(M_MAX)) begin
            n_cur <= n_cur + 1'b1;
            st <= S_LOOP;
          end else begin
            m_cur <= dv_q[MW-1:0] + MW'(dv_q[0]);
            st <= S_V;
          end
        end
        S_V: if (dv_fin) begin
          if (vco_ok && (!found || delta < best_d)) begin
            found  <= 1'b1;
            best_v <= dv_q[FW-1:0];
            best_d <= delta;
            n_keep <= n_cur;
            m_keep <= m_cur;
          end
          n_cur <= n_cur + 1'b1;
          st <= S_LOOP;
        end
        S_RATE: if (dv_fin) begin
          lane_mbps <= dv_q[RW-1:0];
          n_best <= n_keep; m_best <= m_keep;
          done <= 1'b1; err <= 1'b0;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int FW = 32,
  parameter int NW = 12,
  parameter int MW = 10,
  parameter int RW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          err,
  input logic          busy,
  input logic [FW-1:0] fref_r,
  input logic [NW-1:0] n_best,
  input logic [MW-1:0] m_best,
  input logic [RW-1:0] lane_mbps
);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_hold_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(n_best) && $stable(m_best) && $stable(lane_mbps) && $stable(err)));

  a_r8_err_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> (n_best == '0 && m_best == '0 && lane_mbps == '0));

  a_r4_m_even_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (!m_best[0] && m_best >= MW'(6) && m_best <= MW'(512)));

  a_r7_rate_window: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (lane_mbps >= RW'(80) && lane_mbps <= RW'(1500)));

  a_r3_n_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> (n_best != '0));

  a_r10_inputs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fref_r));
endmodule

bind pll_div_search pll_div_search_chk #(.FW(FW), .NW(NW), .MW(MW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .err(err), .busy(busy),
  .fref_r(fref_r), .n_best(n_best), .m_best(m_best), .lane_mbps(lane_mbps)
);

// File: tb/pll_div_search_bench.sv
module pll_div_search_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, start;
  logic [31:0] fref_hz, pclk_khz;
  logic [5:0]  bpp;
  logic [2:0]  lanes;
  logic [11:0] n_best;
  logic [9:0]  m_best;
  logic [10:0] lane_mbps;
  logic        done, err;

  int total = 0, bad = 0;
  bit finished = 0;

  pll_div_search u_pll_div_search (
    .clk(clk), .rst_n(rst_n), .start(start), .fref_hz(fref_hz), .pclk_khz(pclk_khz),
    .bpp(bpp), .lanes(lanes), .n_best(n_best), .m_best(m_best),
    .lane_mbps(lane_mbps), .done(done), .err(err));

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input longint unsigned fr, pk, bp, ln,
                                output longint unsigned en, em, er, ee);
    longint unsigned r, t, mb, th, nlo, nhi, m, v, d, bd, bv;
    bit f;
    r = bp / ln;
    t = ((pk * r * 10) / 8) / 1000;
    mb = (pk != 0 && t < 1500) ? t : 1000;
    th = mb * 1000000;
    nlo = (fr + 39999999) / 40000000;
    nhi = fr / 5000000;
    f = 0; bd = 0; bv = 0; en = 0; em = 0;
    for (longint unsigned n = nlo; n <= nhi; n++) begin
      m = th * n / fr;
      if (m < 6 || m > 512) continue;
      m = m + (m % 2);
      v = m * fr / n;
      if (v < 80000000 || v > 1500000000) continue;
      d = (v > th) ? v - th : th - v;
      if (!f || d < bd) begin f = 1; bd = d; bv = v; en = n; em = m; end
    end
    ee = f ? 0 : 1;
    er = f ? (bv + 999999) / 1000000 : 0;
  endfunction

  task automatic launch(longint unsigned fr, pk, bp, ln);
    @(negedge clk);
    fref_hz = fr[31:0]; pclk_khz = pk[31:0]; bpp = bp[5:0]; lanes = ln[2:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic compare(string tag, longint unsigned fr, pk, bp, ln);
    longint unsigned en, em, er, ee;
    model(fr, pk, bp, ln, en, em, er, ee);
    chk({tag, " R3 R6 n_best"}, n_best, en);
    chk({tag, " R4 m_best"}, m_best, em);
    chk({tag, " R7 lane_mbps"}, lane_mbps, er);
    chk({tag, " R8 err"}, err, ee);
  endtask

  task automatic run_one(string tag, longint unsigned fr, pk, bp, ln);
    launch(fr, pk, bp, ln);
    while (!done) @(negedge clk);
    compare(tag, fr, pk, bp, ln);
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, done, 0);
    compare({tag, " R9 held"}, fr, pk, bp, ln);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    int cnt;
    seed = $urandom(32'd2024);
    rst_n = 1'b0; start = 1'b0;
    fref_hz = 0; pclk_khz = 0; bpp = 0; lanes = 1;
    repeat (4) @(negedge clk);
    chk("R11 reset done", done, 0);
    chk("R11 reset err", err, 0);
    chk("R11 reset n_best", n_best, 0);
    chk("R11 reset m_best", m_best, 0);
    chk("R11 reset lane_mbps", lane_mbps, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_one("R1 typical", 24000000, 148500, 24, 4);
    run_one("R1 t=1499", 5000000, 299800, 16, 4);
    run_one("R2 pclk zero", 24000000, 0, 24, 4);
    run_one("R2 t=1500 fallback", 24000000, 50000, 24, 1);
    run_one("R2 huge pclk", 27000000, 400000, 24, 1);
    run_one("R3 fref 5MHz", 5000000, 0, 24, 4);
    run_one("R3 fref 200MHz", 200000000, 100000, 24, 4);
    run_one("R8 fref 4MHz", 4000000, 148500, 24, 4);
    run_one("R8 fref below 5MHz", 4999999, 148500, 24, 4);
    run_one("R4 m too small", 24000000, 1000, 16, 4);
    run_one("R5 vco below window", 5000000, 14000, 16, 4);
    run_one("R5 vco at 80MHz", 5000000, 16000, 16, 4);

    for (int i = 0; i < 30; i++) begin
      longint unsigned fr, pk, bp, ln;
      int unsigned sel;
      fr = 5000000 + $urandom_range(0, 95000000);
      pk = $urandom_range(0, 300000);
      sel = $urandom_range(0, 2);
      bp = (sel == 0) ? 16 : (sel == 1) ? 18 : 24;
      ln = $urandom_range(1, 4);
      run_one("R6 random", fr, pk, bp, ln);
    end

    launch(24000000, 148500, 24, 4);
    repeat (30) @(negedge clk);
    fref_hz = 60000000; pclk_khz = 20000; bpp = 16; lanes = 2;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    compare("R10 start ignored", 24000000, 148500, 24, 4);
    cnt = 0;
    repeat (300) begin
      @(negedge clk);
      if (done) cnt++;
    end
    chk("R10 no second search", cnt, 0);
    compare("R10 R9 outputs kept", 24000000, 148500, 24, 4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule